// File: doc/BRIEF.md
# Station Management Serial Controller

This block drives a two-wire management bus toward external PHY devices. One output is a divided clock. The other is a data line that the block drives, or releases when it needs to listen. Software reaches the block through a small 64-bit register port. It sets up the clock divider and the frame options, and it loads a 16-bit data word. It then writes a command word that names a PHY, a register or device, and an operation. The controller shifts out one complete management frame, which holds the following in order: an optional 32-bit preamble of ones, a start pattern, two operation bits, the PHY address, the register or device address, a two-bit turnaround and sixteen data bits.

One mode bit selects between the short-address frame format and the extended-address frame format. The same two-bit operation field is interpreted differently in each mode. In extended mode, an access to a register takes two frames: an address frame that carries the 16-bit register number from the write-data register, then a separate read or write frame. The block reports progress through a pending flag and a valid flag in the write-data and read-data registers. It has no separate busy/done handshake. Software polls pending until it clears, then checks valid.

Top module: `mdio_station`

## Requirements
- R1: After reset, every register reads zero, the clock output is low and the data line is released (output enable low).
- R2: The register port decodes byte offsets as follows. 0x00 is the command: register/device address in bits [4:0], PHY address in bits [12:8], operation in bits [17:16], so it reads back masked by 0x0003_1F1F. 0x08 holds write data in bits [15:0]. 0x10 holds read data. 0x18 is the configuration, which reads back masked by 0x011F_BFFF. 0x20 is the enable in bit 0.
- R3: A command write starts a frame only when the enable bit is set and neither pending flag is set. A rejected command write leaves the command register unchanged and produces no clock activity.
- R4: A frame is sent MSB first in this order: 32 ones when configuration bit 12 is set, the start pattern, the wire opcode, 5 PHY bits, 5 address bits, the turnaround, then 16 data bits. The start pattern is 01 when configuration bit 24 is 0 (short format) and 00 when it is 1 (extended format).
- R5: In short format, operation field 0 writes (wire opcode 01) and 1 reads (wire opcode 10). In extended format, the field goes to the wire unchanged: 0 is an address frame, 1 is a write, 3 is a read and 2 is a read.
- R6: During a read frame, the data line is released from the first turnaround bit through the last data bit. During write and address frames, the block drives turnaround 10 followed by the write-data word.
- R7: While a frame runs, the clock output changes level every (bits [7:0] + 1) core clocks and starts low. Between frames, it rests at the level in configuration bit 13.
- R8: The data output changes only on falling clock edges. The input is sampled on rising clock edges.
- R9: Write-data bit 17 (pending) is set from the command through the end of a write or address frame. Bit 16 (valid) is cleared at the start of such a frame and set when it ends.
- R10: Read-data bit 17 (pending) is set for the whole of a read frame. When the frame ends, bits [15:0] hold the 16 sampled data bits, and bit 16 (valid) is set only if the line was low at the second turnaround bit.
- R11: Clearing the enable bit during a frame abandons the frame. The clock returns to its rest level, the line is released, both pending flags clear and valid stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 6 | Register byte offset |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data, combinational from csr_addr |
| mdc | output | 1 | Management clock toward PHYs |
| mdio_out | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_in | input | 1 | Data line as seen on the pin |

## Verification
A short-format write with the preamble enabled checks the full 64-bit frame, the clock period and the completion flags of a write. A short-format read without preamble, answered by a responder in the bench, shows that the line is released at turnaround and that the 16 data bits are captured in order. Extended-format address, write, read and read-increment frames use a different divider. Comparing them against the short-format frames shows the start pattern and the opcode mapping, which is the only place the two modes differ. An unanswered read, a command issued during a frame, a command issued while disabled, and an enable cleared mid-frame cover the cases where valid must stay low or a command must have no effect.

// File: rtl/mdio_station.sv
module mdio_station #(
  parameter int ADDR_W = 6,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  localparam int FRM_LEN = 32;
  localparam int SH_W = PRE_LEN + FRM_LEN;
  localparam int CNT_W = $clog2(SH_W + 1);
  localparam logic [CNT_W-1:0] TA1_LEFT = CNT_W'(18);
  localparam logic [CNT_W-1:0] TA2_LEFT = CNT_W'(17);
  localparam logic [CNT_W-1:0] DAT_LEFT = CNT_W'(16);

  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_WD  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_RD  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(8'h20);

  logic [4:0]  c_reg, c_phy;
  logic [1:0]  c_op;
  logic [15:0] wdat, rdat;
  logic        wr_pend, wr_val, rd_pend, rd_val;
  logic [7:0]  phase;
  logic [3:0]  samp;
  logic [4:0]  samp_hi;
  logic        pre_en, idle_lvl, samp_mode, c45, en;
  logic        busy, mdc_q, is_rd, ta_ok;
  logic [CNT_W-1:0] left;
  logic [SH_W-1:0]  sh;
  logic [7:0]  cnt;

  logic unused_bits;
  assign unused_bits = ^{csr_wdata[63:25], csr_wdata[23:21]};

  wire [4:0]  n_reg = csr_wdata[4:0];
  wire [4:0]  n_phy = csr_wdata[12:8];
  wire [1:0]  n_op  = csr_wdata[17:16];
  wire        n_rd  = c45 ? n_op[1] : n_op[0];
  wire [1:0]  w_op  = c45 ? n_op : (n_op[0] ? 2'b10 : 2'b01);
  wire [31:0] frame = {1'b0, ~c45, w_op, n_phy, n_reg,
                       n_rd ? 2'b11 : 2'b10, n_rd ? 16'hFFFF : wdat};
  wire accept = csr_we && csr_addr == A_CMD && en && !wr_pend && !rd_pend;
  wire tick   = busy && cnt == phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {c_reg, c_phy, c_op, wdat, rdat} <= '0;
      {wr_pend, wr_val, rd_pend, rd_val} <= '0;
      {phase, samp, samp_hi, pre_en, idle_lvl, samp_mode, c45, en} <= '0;
      {busy, mdc_q, is_rd, ta_ok} <= '0;
      left <= '0;
      sh   <= '0;
      cnt  <= '0;
    end else begin
      if (csr_we) begin
        case (csr_addr)
          A_WD:  wdat <= csr_wdata[15:0];
          A_CFG: begin
            phase     <= csr_wdata[7:0];
            samp      <= csr_wdata[11:8];
            pre_en    <= csr_wdata[12];
            idle_lvl  <= csr_wdata[13];
            samp_mode <= csr_wdata[15];
            samp_hi   <= csr_wdata[20:16];
            c45       <= csr_wdata[24];
          end
          A_EN:    en <= csr_wdata[0];
          default: ;
        endcase
      end
      if (accept) begin
        c_reg <= n_reg;
        c_phy <= n_phy;
        c_op  <= n_op;
        busy  <= 1'b1;
        mdc_q <= 1'b0;
        cnt   <= '0;
        is_rd <= n_rd;
        ta_ok <= 1'b0;
        left  <= pre_en ? CNT_W'(SH_W) : CNT_W'(FRM_LEN);
        sh    <= pre_en ? {{PRE_LEN{1'b1}}, frame} : {frame, {PRE_LEN{1'b0}}};
        if (n_rd) begin
          rd_pend <= 1'b1;
          rd_val  <= 1'b0;
        end else begin
          wr_pend <= 1'b1;
          wr_val  <= 1'b0;
        end
      end else if (busy && !en) begin
        busy    <= 1'b0;
        rd_pend <= 1'b0;
        wr_pend <= 1'b0;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 8'd1;
        if (tick && !mdc_q) begin
          mdc_q <= 1'b1;
          if (is_rd && left == TA2_LEFT) ta_ok <= !mdio_in;
          if (is_rd && left <= DAT_LEFT) rdat <= {rdat[14:0], mdio_in};
        end else if (tick) begin
          mdc_q <= 1'b0;
          sh    <= sh << 1;
          left  <= left - 1'b1;
          if (left == CNT_W'(1)) begin
            busy <= 1'b0;
            if (is_rd) begin
              rd_pend <= 1'b0;
              rd_val  <= ta_ok;
            end else begin
              wr_pend <= 1'b0;
              wr_val  <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign mdc      = (busy && en) ? mdc_q : idle_lvl;
  assign mdio_oe  = busy && en && !(is_rd && left <= TA1_LEFT);
  assign mdio_out = mdio_oe & sh[SH_W-1];

  always_comb begin
    case (csr_addr)
      A_CMD:   csr_rdata = {46'd0, c_op, 3'd0, c_phy, 3'd0, c_reg};
      A_WD:    csr_rdata = {46'd0, wr_pend, wr_val, wdat};
      A_RD:    csr_rdata = {46'd0, rd_pend, rd_val, rdat};
      A_CFG:   csr_rdata = {39'd0, c45, 3'd0, samp_hi, samp_mode, 1'b0,
                            idle_lvl, pre_en, samp, phase};
      A_EN:    csr_rdata = {63'd0, en};
      default: csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_station_chk.sv
module mdio_station_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mdc,
  input logic             mdio_oe,
  input logic             mdio_out,
  input logic             en,
  input logic             busy,
  input logic             is_rd,
  input logic [CNT_W-1:0] left,
  input logic             idle_lvl,
  input logic             rd_pend,
  input logic             wr_pend,
  input logic [4:0]       c_reg,
  input logic [4:0]       c_phy,
  input logic [1:0]       c_op
);
  a_r11_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!mdio_oe && mdc == idle_lvl));

  a_r7_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc == idle_lvl && !mdio_oe));

  a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_rd && left <= CNT_W'(18)) |-> !mdio_oe);

  a_r8_out_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && mdc && $past(busy && en && mdc)) |-> $stable(mdio_out));

  a_r9_busy_pending: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((rd_pend || wr_pend) && $onehot0({rd_pend, wr_pend})));

  a_r3_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_pend || wr_pend) && $past(rd_pend || wr_pend)) |->
      ($stable(c_reg) && $stable(c_phy) && $stable(c_op)));
endmodule

bind mdio_station mdio_station_chk #(.CNT_W(CNT_W)) u_chk (
  .clk, .rst_n, .mdc, .mdio_oe, .mdio_out, .en, .busy, .is_rd, .left,
  .idle_lvl, .rd_pend, .wr_pend, .c_reg, .c_phy, .c_op
);

// File: tb/mdio_station_test.sv
module mdio_station_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [5:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int nr = 0;
  bit cap_on = 1'b0;
  logic [63:0] rsp = '1;
  logic  capb [64];
  logic  capo [64];
  time   rt   [64];

  mdio_station uut (
    .clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .csr_rdata,
    .mdc, .mdio_out, .mdio_oe, .mdio_in
  );

  always #10 clk = ~clk;

  always @(posedge mdc) begin
    if (cap_on && nr < 64) begin
      capb[nr] = mdio_out;
      capo[nr] = mdio_oe;
      rt[nr]   = $time;
      nr = nr + 1;
    end
  end

  always @(negedge mdc) mdio_in = (nr < 64) ? rsp[63-nr] : 1'b1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic csr_wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [5:0] a, output logic [63:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic wait_idle();
    logic [63:0] w, r;
    for (int i = 0; i < 5000; i++) begin
      csr_rd(6'h08, w);
      csr_rd(6'h10, r);
      if (!w[17] && !r[17]) break;
    end
  endtask

  // Runs one frame; wop is the wire opcode that R5 assigns to op in the given mode.
  task automatic do_frame(input string req, input bit c45, input bit pre, input logic [7:0] ph,
                          input logic [1:0] op, input logic [1:0] wop, input bit rd,
                          input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] wd, input logic [15:0] rdv);
    logic [31:0] f;
    logic [63:0] exp, v;
    int n, bad;
    n = pre ? 64 : 32;
    f = {c45 ? 2'b00 : 2'b01, wop, phy, ra, 2'b10, wd};
    exp = pre ? {32'hFFFF_FFFF, f} : {f, 32'd0};
    rsp = '1;
    if (rd) begin
      rsp[63-(n-17)] = 1'b0;
      for (int j = 0; j < 16; j++) rsp[63-(n-16+j)] = rdv[15-j];
    end
    csr_wr(6'h18, {39'd0, c45, 11'd0, pre, 4'd0, ph});
    csr_wr(6'h08, {48'd0, wd});
    nr = 0; cap_on = 1'b1; mdio_in = rsp[63];
    csr_wr(6'h00, {46'd0, op, 3'd0, phy, 3'd0, ra});
    csr_rd(rd ? 6'h10 : 6'h08, v);
    chk({req, " R9 R10 pending at start"}, {62'd0, v[17:16]}, 64'd2);
    wait_idle();
    cap_on = 1'b0;
    chk({req, " R4 bit count"}, 64'(nr), 64'(n));
    bad = 0;
    for (int i = 0; i < n && i < nr; i++) begin
      if (capo[i] !== ((rd && i >= n - 18) ? 1'b0 : 1'b1)) bad++;
      else if (capo[i] && capb[i] !== exp[63-i]) bad++;
    end
    chk({req, " R4 R5 R6 frame bits"}, 64'(bad), 64'd0);
    if (nr > 1) chk({req, " R7 mdc period ns"}, 64'(rt[1] - rt[0]), 64'((ph + 1) * 40));
    if (rd) begin
      csr_rd(6'h10, v);
      chk({req, " R10 read result"}, v, {46'd0, 2'b01, rdv});
    end else begin
      csr_rd(6'h08, v);
      chk({req, " R9 write result"}, v, {46'd0, 2'b01, wd});
    end
  endtask

  task automatic t_reset();
    logic [63:0] v;
    for (int k = 0; k < 5; k++) begin
      csr_rd(6'(k * 8), v);
      chk("R1 register reset", v, 64'd0);
    end
    chk("R1 mdc low", 64'(mdc), 64'd0);
    chk("R1 line released", 64'(mdio_oe), 64'd0);
  endtask

  task automatic t_masks();
    logic [63:0] v;
    csr_wr(6'h18, '1);
    csr_rd(6'h18, v);
    chk("R2 config mask", v, 64'h0000_0000_011F_BFFF);
    csr_wr(6'h18, 64'd0);
    csr_wr(6'h20, 64'd1);
    csr_rd(6'h20, v);
    chk("R2 enable bit", v, 64'd1);
    rsp = '1; mdio_in = 1'b1;
    csr_wr(6'h00, '1);
    csr_rd(6'h00, v);
    chk("R2 command mask", v, 64'h0000_0000_0003_1F1F);
    csr_rd(6'h10, v);
    chk("R10 read started", 64'(v[17]), 64'd1);
    wait_idle();
    csr_rd(6'h10, v);
    chk("R10 unanswered read not valid", {62'd0, v[17:16]}, 64'd0);
  endtask

  task automatic t_ignore();
    logic [63:0] v;
    csr_wr(6'h18, 64'd3);
    csr_wr(6'h08, 64'h1111);
    nr = 0; cap_on = 1'b1; rsp = '1;
    csr_wr(6'h00, 64'h0000_0203);
    csr_wr(6'h00, 64'h0001_0909);
    csr_rd(6'h00, v);
    chk("R3 busy command ignored", v, 64'h0000_0203);
    wait_idle();
    cap_on = 1'b0;
    csr_rd(6'h10, v);
    chk("R3 no read started", 64'(v[17]), 64'd0);
    chk("R3 only one frame", 64'(nr), 64'd32);
    csr_wr(6'h20, 64'd0);
    nr = 0; cap_on = 1'b1;
    csr_wr(6'h00, 64'h0001_0505);
    repeat (40) @(negedge clk);
    cap_on = 1'b0;
    csr_rd(6'h00, v);
    chk("R3 disabled command ignored", v, 64'h0000_0203);
    chk("R3 no clock while disabled", 64'(nr), 64'd0);
    csr_wr(6'h20, 64'd1);
  endtask

  task automatic t_abort();
    logic [63:0] v;
    csr_wr(6'h18, 64'h2001);
    repeat (2) @(negedge clk);
    chk("R7 rest level high", 64'(mdc), 64'd1);
    rsp = '1;
    csr_wr(6'h00, 64'h0001_0101);
    repeat (20) @(negedge clk);
    csr_wr(6'h20, 64'd0);
    @(negedge clk);
    chk("R11 mdc at rest", 64'(mdc), 64'd1);
    chk("R11 line released", 64'(mdio_oe), 64'd0);
    csr_rd(6'h10, v);
    chk("R11 pending and valid clear", {62'd0, v[17:16]}, 64'd0);
    csr_wr(6'h20, 64'd1);
    csr_wr(6'h18, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    do_frame("short write", 1'b0, 1'b1, 8'd1, 2'd0, 2'b01, 1'b0, 5'd5, 5'h12, 16'hA5C3, 16'h0);
    do_frame("short read", 1'b0, 1'b0, 8'd1, 2'd1, 2'b10, 1'b1, 5'd9, 5'h03, 16'h0, 16'h1234);
    do_frame("ext address", 1'b1, 1'b0, 8'd2, 2'd0, 2'b00, 1'b0, 5'd3, 5'h07, 16'hBEEF, 16'h0);
    do_frame("ext read", 1'b1, 1'b0, 8'd2, 2'd3, 2'b11, 1'b1, 5'd3, 5'h07, 16'h0, 16'h5A5A);
    do_frame("ext write", 1'b1, 1'b1, 8'd0, 2'd1, 2'b01, 1'b0, 5'd1, 5'h1E, 16'h0F0F, 16'h0);
    do_frame("ext read inc", 1'b1, 1'b0, 8'd2, 2'd2, 2'b10, 1'b1, 5'd17, 5'h01, 16'h0, 16'h00C3);
    t_ignore();
    t_abort();
    summary();
  end
endmodule